// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Selectable Write-Miss Handling

This block is a direct-mapped, write-through data cache that sits between a processor load/store port and a word-wide memory port. It holds 128 lines of 16 words each, addressed by an 18-bit word address. Every line carries one tag and a valid bit for each word, so a line may be only partly present. Reads that miss are served by demand fetch with read-through: the missing word comes back from memory first and is handed to the processor at once, and the rest of the line follows.

Every store goes to memory through a four-entry write buffer, so the processor waits only when that buffer is full. A two-bit mode input chooses at run time what a write miss does to the cache. It can fetch the block and merge the store, allocate a partial line, bypass the cache, or write the word before the tag check and invalidate the line.

The controller has three states. In IDLE it serves hits and accepts stores. IDLE moves to DRAIN on a read miss or on a write miss in fetch mode. DRAIN moves to FILL once the write buffer is empty. FILL moves back to IDLE when the sixteenth word of the line has been acknowledged.

Top module: `cwm_top`

## Requirements
- R1: Word address bits [17:11] are the tag, bits [10:4] select the line and bits [3:0] select the word. Two addresses with the same line bits and different tags evict each other.
- R2: A read hits only when the line tag matches and the addressed word's valid bit is set. A hit raises `cpu_done` in the cycle of the request and issues no memory read.
- R3: On a read miss the first memory read is the requested word, and `cpu_done` with that word comes on its acknowledge. The remaining 15 words follow in wraparound order, starting with the next word index.
- R4: A read of an invalid word in a line whose tag matches refills only the missing words and keeps the tag. After that refill, every word of the line hits.
- R5: Stores enter a 4-entry write buffer and complete in their request cycle while it has room. A store that finds it full waits. Buffered stores reach memory in issue order.
- R6: A read miss issues no memory read until the write buffer is empty, so it returns the latest stored value.
- R7: Mode 0 (fetch on write): a write miss reads all 16 words of the block from memory before `cpu_done`. Afterwards the whole line hits, and the stored word holds the new value.
- R8: Mode 1 (allocate without fetch): a write miss installs the new tag with only the written word valid, and reads no memory. That word then hits, and every other word of the line misses.
- R9: Mode 2 (bypass): a write miss leaves the line unchanged, so the old block still hits and the written address misses.
- R10: Mode 3 (write before tag check): a write miss invalidates the indexed line. A later read of the old block misses and returns the memory value, not the stored word.
- R11: A write hit (tag match and at least one valid word) updates the cached word in every mode.
- R12: After reset no line holds valid data, and neither `cpu_done` nor `mem_req` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wmode | input | 2 | Write-miss mode: 0 fetch, 1 allocate, 2 bypass, 3 invalidate |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 for store, 0 for load |
| cpu_addr | input | 18 | Word address |
| cpu_wdata | input | 32 | Store data |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_rdata | output | 32 | Load data, valid with `cpu_done` |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 for memory write, 0 for read |
| mem_addr | output | 18 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | One-cycle acknowledge of the current memory request |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The hardest cases to reach from the ports are the corrupted line left by mode 3 and the partial line left by mode 1. Reaching either takes a specific history on one line index. The stimulus first fills a line completely, then stores to a conflicting tag under the chosen mode, and then reads both the old and the new block. Hit or miss is judged by counting memory reads and completion latency. The full-buffer stall and the read-after-store ordering need stores to pile up, so those tests switch the memory model to a long latency and issue five back-to-back stores, followed at once by a load of a freshly stored address.

// File: rtl/cwm_pkg.sv
package cwm_pkg;
    typedef enum logic [1:0] {
        WM_FETCH    = 2'd0,
        WM_VALIDATE = 2'd1,
        WM_AROUND   = 2'd2,
        WM_INVAL    = 2'd3
    } wmode_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_DRAIN = 2'd1,
        S_FILL  = 2'd2
    } cwm_state_e;
endpackage

// File: rtl/cwm_wbuf.sv
module cwm_wbuf #(
    parameter int AW    = 18,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          grant,
    input  logic          ack,
    output logic          full,
    output logic          empty,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data
);
    localparam int PW = $clog2(DEPTH);

    logic [AW-1:0] addr_q [DEPTH];
    logic [DW-1:0] data_q [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [PW:0]   cnt_q;
    logic          pop;

    assign empty     = (cnt_q == '0);
    assign full      = (cnt_q == (PW+1)'(DEPTH));
    assign pop       = grant && ack && !empty;
    assign head_addr = addr_q[rp_q];
    assign head_data = data_q[rp_q];

    always_ff @(posedge clk) begin
        if (push && !full) begin
            addr_q[wp_q] <= push_addr;
            data_q[wp_q] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push && !full) wp_q <= wp_q + 1'b1;
            if (pop)           rp_q <= rp_q + 1'b1;
            cnt_q <= cnt_q + (PW+1)'(push && !full) - (PW+1)'(pop);
        end
    end
endmodule

// File: rtl/cwm_store.sv
module cwm_store #(
    parameter int TAGW = 7,
    parameter int IDXW = 7,
    parameter int OFFW = 4,
    parameter int DW   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDXW-1:0]   line,
    input  logic [OFFW-1:0]   word,
    output logic [TAGW-1:0]   tag_o,
    output logic [(1<<OFFW)-1:0] vld_o,
    output logic [DW-1:0]     rdata_o,
    input  logic              clr,
    input  logic [TAGW-1:0]   new_tag,
    input  logic              inv,
    input  logic              wr,
    input  logic              wr_vld,
    input  logic [DW-1:0]     wdata
);
    localparam int LINES = 1 << IDXW;
    localparam int WORDS = 1 << OFFW;

    logic [TAGW-1:0]  tag_q [LINES];
    logic [WORDS-1:0] vld_q [LINES];
    logic [DW-1:0]    dat_q [LINES*WORDS];

    assign tag_o   = tag_q[line];
    assign vld_o   = vld_q[line];
    assign rdata_o = dat_q[{line, word}];

    // Line clear comes first; a word write in the same cycle then sets its bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                tag_q[i] <= '0;
                vld_q[i] <= '0;
            end
        end else begin
            if (clr) begin
                tag_q[line] <= new_tag;
                vld_q[line] <= '0;
            end else if (inv) begin
                vld_q[line] <= '0;
            end
            if (wr && wr_vld) vld_q[line][word] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr) dat_q[{line, word}] <= wdata;
    end
endmodule

// File: rtl/cwm_ctrl.sv
module cwm_ctrl
    import cwm_pkg::*;
#(
    parameter int AW   = 18,
    parameter int DW   = 32,
    parameter int IDXW = 7,
    parameter int OFFW = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             wmode,
    input  logic                   cpu_req,
    input  logic                   cpu_we,
    input  logic [AW-1:0]          cpu_addr,
    input  logic [DW-1:0]          cpu_wdata,
    output logic                   cpu_done,
    output logic [DW-1:0]          cpu_rdata,
    output logic [IDXW-1:0]        st_line,
    output logic [OFFW-1:0]        st_word,
    input  logic [AW-IDXW-OFFW-1:0] st_tag,
    input  logic [(1<<OFFW)-1:0]   st_vld,
    input  logic [DW-1:0]          st_rdata,
    output logic                   st_clr,
    output logic [AW-IDXW-OFFW-1:0] st_new_tag,
    output logic                   st_inv,
    output logic                   st_wr,
    output logic                   st_wr_vld,
    output logic [DW-1:0]          st_wdata,
    output logic                   wb_push,
    input  logic                   wb_full,
    input  logic                   wb_empty,
    output logic                   fill_req,
    output logic [AW-1:0]          fill_addr,
    input  logic                   mem_ack,
    input  logic [DW-1:0]          mem_rdata
);
    localparam int TAGW = AW - IDXW - OFFW;

    cwm_state_e    st_q, st_d;
    logic [AW-1:0] addr_q;
    logic          we_q;
    logic [OFFW-1:0] cnt_q;
    logic          grab;

    logic [AW-1:0]   src;
    logic [TAGW-1:0] a_tag;
    logic [IDXW-1:0] a_idx;
    logic [OFFW-1:0] a_off, fill_off;
    logic            tag_hit, line_live, word_ok;

    assign src        = (st_q == S_IDLE) ? cpu_addr : addr_q;
    assign a_tag      = src[AW-1 -: TAGW];
    assign a_idx      = src[OFFW +: IDXW];
    assign a_off      = src[OFFW-1:0];
    assign fill_off   = addr_q[OFFW-1:0] + cnt_q;
    assign st_line    = a_idx;
    assign st_word    = (st_q == S_FILL) ? fill_off : a_off;
    assign st_new_tag = a_tag;
    assign fill_addr  = {a_tag, a_idx, fill_off};
    assign tag_hit    = (st_tag == a_tag);
    assign line_live  = |st_vld;
    assign word_ok    = st_vld[st_word];

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            we_q   <= 1'b0;
            cnt_q  <= '0;
        end else if (grab) begin
            addr_q <= cpu_addr;
            we_q   <= cpu_we;
            cnt_q  <= '0;
        end else if (st_q == S_FILL && mem_ack) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        st_d      = st_q;
        cpu_done  = 1'b0;
        cpu_rdata = st_rdata;
        wb_push   = 1'b0;
        st_clr    = 1'b0;
        st_inv    = 1'b0;
        st_wr     = 1'b0;
        st_wr_vld = 1'b0;
        st_wdata  = cpu_wdata;
        fill_req  = 1'b0;
        grab      = 1'b0;
        unique case (st_q)
            S_IDLE: begin
                if (cpu_req && !cpu_we) begin
                    if (tag_hit && word_ok) begin
                        cpu_done = 1'b1;
                    end else begin
                        st_clr = !tag_hit;
                        grab   = 1'b1;
                        st_d   = S_DRAIN;
                    end
                end else if (cpu_req && !wb_full) begin
                    wb_push = 1'b1;
                    if (tag_hit && line_live) begin
                        st_wr     = 1'b1;
                        st_wr_vld = 1'b1;
                        cpu_done  = 1'b1;
                    end else begin
                        unique case (wmode_e'(wmode))
                            WM_FETCH: begin
                                st_clr    = 1'b1;
                                st_wr     = 1'b1;
                                st_wr_vld = 1'b1;
                                grab      = 1'b1;
                                st_d      = S_DRAIN;
                            end
                            WM_VALIDATE: begin
                                st_clr    = 1'b1;
                                st_wr     = 1'b1;
                                st_wr_vld = 1'b1;
                                cpu_done  = 1'b1;
                            end
                            WM_AROUND: cpu_done = 1'b1;
                            WM_INVAL: begin
                                st_wr    = 1'b1;
                                st_inv   = 1'b1;
                                cpu_done = 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
            end
            S_DRAIN: begin
                if (wb_empty) st_d = S_FILL;
            end
            S_FILL: begin
                fill_req = 1'b1;
                st_wdata = mem_rdata;
                if (mem_ack) begin
                    st_wr     = !word_ok;
                    st_wr_vld = 1'b1;
                    if (cnt_q == '0 && !we_q) begin
                        cpu_done  = 1'b1;
                        cpu_rdata = mem_rdata;
                    end
                    if (&cnt_q) begin
                        st_d = S_IDLE;
                        if (we_q) cpu_done = 1'b1;
                    end
                end
            end
            default: st_d = S_IDLE;
        endcase
    end
endmodule

// File: rtl/cwm_top.sv
module cwm_top #(
    parameter int AW   = 18,
    parameter int DW   = 32,
    parameter int IDXW = 7,
    parameter int OFFW = 4,
    parameter int WBD  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    wmode,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_done,
    output logic [DW-1:0] cpu_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);
    localparam int TAGW  = AW - IDXW - OFFW;
    localparam int WORDS = 1 << OFFW;

    logic [IDXW-1:0]  st_line;
    logic [OFFW-1:0]  st_word;
    logic [TAGW-1:0]  st_tag, st_new_tag;
    logic [WORDS-1:0] st_vld;
    logic [DW-1:0]    st_rdata, st_wdata;
    logic             st_clr, st_inv, st_wr, st_wr_vld;
    logic             wb_push, wb_full, wb_empty;
    logic [AW-1:0]    wb_addr, fill_addr;
    logic [DW-1:0]    wb_data;
    logic             fill_req;

    cwm_ctrl #(.AW(AW), .DW(DW), .IDXW(IDXW), .OFFW(OFFW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wmode(wmode),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .st_line(st_line), .st_word(st_word), .st_tag(st_tag), .st_vld(st_vld),
        .st_rdata(st_rdata), .st_clr(st_clr), .st_new_tag(st_new_tag), .st_inv(st_inv),
        .st_wr(st_wr), .st_wr_vld(st_wr_vld), .st_wdata(st_wdata),
        .wb_push(wb_push), .wb_full(wb_full), .wb_empty(wb_empty),
        .fill_req(fill_req), .fill_addr(fill_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    cwm_store #(.TAGW(TAGW), .IDXW(IDXW), .OFFW(OFFW), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .line(st_line), .word(st_word),
        .tag_o(st_tag), .vld_o(st_vld), .rdata_o(st_rdata),
        .clr(st_clr), .new_tag(st_new_tag), .inv(st_inv),
        .wr(st_wr), .wr_vld(st_wr_vld), .wdata(st_wdata)
    );

    cwm_wbuf #(.AW(AW), .DW(DW), .DEPTH(WBD)) u_wbuf (
        .clk(clk), .rst_n(rst_n), .push(wb_push), .push_addr(cpu_addr),
        .push_data(cpu_wdata), .grant(!fill_req), .ack(mem_ack),
        .full(wb_full), .empty(wb_empty), .head_addr(wb_addr), .head_data(wb_data)
    );

    assign mem_req   = fill_req || !wb_empty;
    assign mem_we    = !fill_req;
    assign mem_addr  = fill_req ? fill_addr : wb_addr;
    assign mem_wdata = wb_data;
endmodule

// File: rtl/cwm_chk.sv
module cwm_chk #(
    parameter int AW = 18,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_req,
    input logic          cpu_we,
    input logic          cpu_done,
    input logic [DW-1:0] cpu_rdata,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ack,
    input logic [DW-1:0] mem_rdata,
    input logic          wb_full,
    input logic          wb_empty
);
    // R6: a line fetch never overlaps pending stores
    p_fill_after_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> wb_empty);

    // R5: a store that meets a full buffer does not complete
    p_full_stalls_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_full && cpu_req && cpu_we) |-> !cpu_done);

    // R5: a memory request stays put until acknowledged
    p_mem_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R3: a load finishing during a fetch carries the word memory returns
    p_forward_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && !cpu_we && mem_req && !mem_we && mem_ack) |-> (cpu_rdata == mem_rdata));

    // R12: nothing completes or goes to memory straight after reset
    p_quiet_reset_r12: assert property (@(posedge clk)
        $rose(rst_n) |-> (!cpu_done && !mem_req));
endmodule

bind cwm_top cwm_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .wb_full(wb_full), .wb_empty(wb_empty)
);

// File: tb/cwm_top_test.sv
module cwm_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  wmode = 2'd2;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [17:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_done;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [17:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;

    int total = 0, bad = 0;
    int lat = 1, wcnt = 0, rd_acks = 0;
    logic [31:0] mem_arr [int];
    logic [31:0] ref_mem [int];
    logic [17:0] rd_log [$];
    logic [31:0] exp_q [$];
    logic [17:0] exp_a [$];
    bit finished = 0;

    always #4 clk = ~clk;

    cwm_top uut (
        .clk(clk), .rst_n(rst_n), .wmode(wmode), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_done(cpu_done),
        .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] init_val(logic [17:0] a);
        return ({14'd0, a} * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [17:0] mk(int t, int i, int o);
        return {7'(t), 7'(i), 4'(o)};
    endfunction

    // memory model: one acknowledge per request after lat wait cycles
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            mem_rdata <= '0;
            wcnt = 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                wcnt = 0;
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem_arr[int'(mem_addr)] = mem_wdata;
                end else begin
                    mem_rdata <= mem_arr.exists(int'(mem_addr)) ? mem_arr[int'(mem_addr)] : init_val(mem_addr);
                    rd_acks++;
                    rd_log.push_back(mem_addr);
                end
            end else begin
                wcnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", what, act, exp);
        end
    endtask

    // driver: issues one request, queues the expected load value
    task automatic op(input bit we, input logic [17:0] a, input logic [31:0] d,
                      output int waits, output int reads);
        int r0;
        @(negedge clk);
        r0 = rd_acks;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        if (we) ref_mem[int'(a)] = d;
        else begin
            exp_q.push_back(ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_val(a));
            exp_a.push_back(a);
        end
        waits = 0;
        #3;
        while (!cpu_done) begin
            @(negedge clk); #3;
            waits++;
        end
        reads = rd_acks - r0;
        @(posedge clk); #1;
        cpu_req = 1'b0;
    endtask

    task automatic quiet();
        repeat (220) @(negedge clk);
    endtask

    // monitor: compares each completed load against the scoreboard
    always begin
        @(negedge clk); #3;
        if (rst_n && cpu_req && cpu_done && !cpu_we) begin
            if (exp_q.size() == 0) begin
                chk(0, "R2 unexpected load completion", 1, 0);
            end else begin
                logic [31:0] e;
                logic [17:0] ea;
                e = exp_q.pop_front();
                ea = exp_a.pop_front();
                chk(cpu_rdata == e, $sformatf("R6 load data addr=%0h", ea), int'(cpu_rdata), int'(e));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired act=1 exp=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int w, r;
        logic [17:0] a_old, g;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #3;
        chk(!cpu_done && !mem_req, "R12 idle after reset", int'({cpu_done, mem_req}), 0);

        // R12 / R3: cold read misses, forwarded word arrives first, wraparound fill
        a_old = mk(3, 5, 14);
        op(0, a_old, 0, w, r);
        chk(w > 0, "R12 cold read misses", w, 1);
        chk(r == 1, "R3 done on first fetched word", r, 1);
        quiet();
        chk(rd_log.size() == 16, "R3 line fill length", rd_log.size(), 16);
        chk(rd_log[0] == a_old, "R3 first fetch is requested word", int'(rd_log[0]), int'(a_old));
        chk(rd_log[1] == mk(3, 5, 15), "R3 second fetch is next word", int'(rd_log[1]), int'(mk(3, 5, 15)));
        chk(rd_log[2] == mk(3, 5, 0), "R3 fetch wraps to word 0", int'(rd_log[2]), int'(mk(3, 5, 0)));

        // R2: hit in the same line
        op(0, mk(3, 5, 2), 0, w, r);
        chk(w == 0 && r == 0, "R2 read hit completes at once", w + r, 0);

        // R1: conflicting tag on the same index evicts
        op(0, mk(9, 5, 2), 0, w, r);
        chk(r > 0, "R1 conflicting tag misses", r, 1);
        quiet();
        op(0, a_old, 0, w, r);
        chk(r > 0, "R1 evicted block misses again", r, 1);
        quiet();

        // R11: write hit updates the cache
        op(1, mk(3, 5, 7), 32'hCAFE_0007, w, r);
        chk(w == 0, "R11 write hit accepted at once", w, 0);
        quiet();
        op(0, mk(3, 5, 7), 0, w, r);
        chk(r == 0, "R11 write hit then read hits", r, 0);

        // R9: bypass mode
        wmode = 2'd2;
        op(1, mk(20, 5, 1), 32'h0A0A_0001, w, r);
        quiet();
        op(0, mk(3, 5, 9), 0, w, r);
        chk(r == 0, "R9 old block still hits", r, 0);
        op(0, mk(20, 5, 1), 0, w, r);
        chk(r > 0, "R9 bypassed address misses", r, 1);
        quiet();

        // R8: allocate without fetch
        wmode = 2'd1;
        op(1, mk(30, 5, 4), 32'hBEEF_0004, w, r);
        chk(r == 0, "R8 no fetch on allocate", r, 0);
        quiet();
        op(0, mk(30, 5, 4), 0, w, r);
        chk(r == 0, "R8 written word hits", r, 0);
        op(0, mk(30, 5, 5), 0, w, r);
        chk(r > 0, "R8 other word misses", r, 1);
        quiet();
        // R4: refill kept tag and written word
        op(0, mk(30, 5, 0), 0, w, r);
        chk(r == 0, "R4 refilled word hits", r, 0);
        op(0, mk(30, 5, 4), 0, w, r);
        chk(r == 0, "R4 earlier valid word still hits", r, 0);

        // R10: write before tag check invalidates the line
        wmode = 2'd3;
        op(1, mk(40, 5, 3), 32'hDEAD_0003, w, r);
        quiet();
        op(0, mk(30, 5, 3), 0, w, r);
        chk(r > 0, "R10 old block misses after invalidate", r, 1);
        quiet();

        // R7: fetch on write
        wmode = 2'd0;
        op(1, mk(50, 5, 6), 32'hF00D_0006, w, r);
        chk(r == 16, "R7 write miss fetches full block", r, 16);
        op(0, mk(50, 5, 6), 0, w, r);
        chk(r == 0, "R7 written word hits", r, 0);
        op(0, mk(50, 5, 11), 0, w, r);
        chk(r == 0, "R7 rest of block hits", r, 0);
        quiet();

        // R5: four stores buffered, fifth stalls, memory sees last value
        lat = 6;
        wmode = 2'd2;
        g = mk(60, 9, 0);
        for (int k = 0; k < 5; k++) begin
            op(1, g, 32'h1000 + 32'(k), w, r);
            if (k < 4) chk(w == 0, "R5 store accepted without stall", w, 0);
            else       chk(w > 0, "R5 store stalls on full buffer", w, 1);
        end
        quiet();
        chk(mem_arr.exists(int'(g)) && mem_arr[int'(g)] == 32'h1004, "R5 stores in order",
            mem_arr.exists(int'(g)) ? int'(mem_arr[int'(g)]) : -1, 32'h1004);

        // R6: read miss right after a buffered store sees the store
        op(1, mk(61, 9, 1), 32'h7777_0001, w, r);
        op(0, mk(61, 9, 1), 0, w, r);
        chk(w > 0, "R6 read waits for drain and fetch", w, 1);
        quiet();

        chk(exp_q.size() == 0, "R2 all loads completed", exp_q.size(), 0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule